// File: doc/BRIEF.md
# Tabu Pair Membership Memory

This block keeps the short-term memory of a pairwise-swap local search: the set of index pairs that were recently committed and may not be swapped again for a while. Every candidate swap the search engine evaluates can be asked about through a check port. The answer arrives one clock later, lined up with a one-stage evaluation pipeline. A lookup costs one read of a single-bit flag, however long the list is.

Storage has two parts. The first is an N×N flag array addressed by the normalised pair. The second is a shift-register queue of TENURE pair entries, which sets when each flag is dropped again. Each commit pushes the new pair into the queue and raises its flag. Once the queue is full, the same commit also retires the oldest entry and lowers that entry's flag. A synchronous clear empties both parts at the start of a new search. The block does not choose moves or compute costs.

Top module: `tabu_pair_mem`

## Requirements
- R1: When `chk_vld` is high in a cycle, `hit_vld` is high in the next cycle. When `chk_vld` is low, both `hit_vld` and `hit` are low in the next cycle.
- R2: A pair is order-free. Checking or committing (a, b) has the same effect as using (b, a).
- R3: After a commit of a pair, a check of that pair issued in any later cycle returns `hit` = 1 until the pair is evicted or cleared. A check issued in the same cycle as a commit sees the list as it was before that commit.
- R4: As long as fewer than TENURE commits have been made since reset or clear, no flag is lowered. Every pair committed in that span is still reported tabu.
- R5: Once TENURE entries are held, each further commit lowers the flag of the oldest entry, so that pair reads `hit` = 0 from the next cycle on. The only exception is the case in R6.
- R6: If a commit both evicts and inserts the same pair, the pair stays tabu. The flag is raised after it is lowered.
- R7: `clr` lowers every flag and empties the queue in one cycle. It takes priority over a commit in the same cycle, and the commit is discarded.
- R8: After reset, every pair reads `hit` = 0 and `hit_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the whole list |
| chk_vld | input | 1 | Membership query valid |
| chk_a | input | $clog2(N) | First index of the queried pair |
| chk_b | input | $clog2(N) | Second index of the queried pair |
| cm_vld | input | 1 | Commit a pair to the list |
| cm_a | input | $clog2(N) | First index of the committed pair |
| cm_b | input | $clog2(N) | Second index of the committed pair |
| hit_vld | output | 1 | Query answer valid, one cycle after `chk_vld` |
| hit | output | 1 | The queried pair is tabu |

## Verification
The bench builds the block with N = 6 and TENURE = 4. With a tenure that short, the queue fills, wraps and evicts many times in a few thousand random cycles. The small index range makes random pairs collide often. That produces duplicate entries in the queue, same-cycle evict-and-insert of one pair, and commits that land on top of a clear, alongside the directed cases for each of these.

// File: rtl/tabu_pair_mem.sv
module tabu_pair_mem #(
  parameter int N      = 16,
  parameter int TENURE = N
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 chk_vld,
  input  logic [$clog2(N)-1:0] chk_a,
  input  logic [$clog2(N)-1:0] chk_b,
  input  logic                 cm_vld,
  input  logic [$clog2(N)-1:0] cm_a,
  input  logic [$clog2(N)-1:0] cm_b,
  output logic                 hit_vld,
  output logic                 hit
);
  localparam int IW = $clog2(N);
  localparam int AW = $clog2(N * N);
  localparam logic [AW-1:0] NW = AW'(N);

  logic [N*N-1:0]  tbl;
  logic [TENURE-1:0] q_v;
  logic [IW-1:0]   q_lo [TENURE];
  logic [IW-1:0]   q_hi [TENURE];

  logic [IW-1:0]   chk_lo, chk_hi, cm_lo, cm_hi;
  logic [AW-1:0]   chk_addr, cm_addr, ev_addr;
  logic            full;

  assign chk_lo   = (chk_a < chk_b) ? chk_a : chk_b;
  assign chk_hi   = (chk_a < chk_b) ? chk_b : chk_a;
  assign cm_lo    = (cm_a < cm_b) ? cm_a : cm_b;
  assign cm_hi    = (cm_a < cm_b) ? cm_b : cm_a;
  assign chk_addr = AW'(chk_lo) * NW + AW'(chk_hi);
  assign cm_addr  = AW'(cm_lo) * NW + AW'(cm_hi);
  assign ev_addr  = AW'(q_lo[TENURE-1]) * NW + AW'(q_hi[TENURE-1]);
  assign full     = q_v[TENURE-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      q_v <= '0;
    end else if (cm_vld) begin
      for (int k = TENURE - 1; k > 0; k--) q_v[k] <= q_v[k-1];
      q_v[0] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cm_vld) begin
      for (int k = TENURE - 1; k > 0; k--) begin
        q_lo[k] <= q_lo[k-1];
        q_hi[k] <= q_hi[k-1];
      end
      q_lo[0] <= cm_lo;
      q_hi[0] <= cm_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tbl <= '0;
    end else if (cm_vld) begin
      if (full) tbl[ev_addr] <= 1'b0;
      tbl[cm_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_vld <= 1'b0;
      hit     <= 1'b0;
    end else begin
      hit_vld <= chk_vld;
      hit     <= chk_vld & tbl[chk_addr];
    end
  end
endmodule

// File: rtl/tabu_pair_mem_chk.sv
module tabu_pair_mem_chk #(
  parameter int N      = 16,
  parameter int TENURE = N
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      clr,
  input logic                      chk_vld,
  input logic                      cm_vld,
  input logic                      hit_vld,
  input logic                      hit,
  input logic [$clog2(N*N)-1:0]    cm_addr,
  input logic [N*N-1:0]            tbl,
  input logic [TENURE-1:0]         q_v
);
  a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |=> hit_vld);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_vld |=> (!hit_vld && !hit));

  a_r3_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_vld && !clr) |=> tbl[$past(cm_addr)]);

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tbl == '0 && q_v == '0));

  a_r4_bits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tbl) <= $countones(q_v));

  a_r4_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_vld && !clr && !q_v[TENURE-1]) |=> ($countones(q_v) == $past($countones(q_v)) + 1));
endmodule

bind tabu_pair_mem tabu_pair_mem_chk #(.N(N), .TENURE(TENURE)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .chk_vld(chk_vld), .cm_vld(cm_vld),
  .hit_vld(hit_vld), .hit(hit), .cm_addr(cm_addr), .tbl(tbl), .q_v(q_v)
);

// File: tb/tabu_pair_mem_bench.sv
`timescale 1ns/1ps
module tabu_pair_mem_bench;
  localparam int N  = 6;
  localparam int T  = 4;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic chk_vld = 1'b0, cm_vld = 1'b0;
  logic [IW-1:0] chk_a = '0, chk_b = '0, cm_a = '0, cm_b = '0;
  logic hit_vld, hit;

  always #4 clk = ~clk;

  tabu_pair_mem #(.N(N), .TENURE(T)) u_tabu_pair_mem (
    .clk(clk), .rst_n(rst_n), .clr(clr), .chk_vld(chk_vld), .chk_a(chk_a),
    .chk_b(chk_b), .cm_vld(cm_vld), .cm_a(cm_a), .cm_b(cm_b),
    .hit_vld(hit_vld), .hit(hit)
  );

  int checks = 0, errs = 0;
  bit mdl [N][N];
  int ql [T], qh [T];
  bit qv [T];

  function automatic bit mdl_hit(int a, int b);
    return (a < b) ? mdl[a][b] : mdl[b][a];
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mdl[i][j] = 1'b0;
    for (int k = 0; k < T; k++) qv[k] = 1'b0;
  endtask

  task automatic mdl_commit(int a, int b);
    int lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    if (qv[T-1]) mdl[ql[T-1]][qh[T-1]] = 1'b0;
    for (int k = T - 1; k > 0; k--) begin
      qv[k] = qv[k-1]; ql[k] = ql[k-1]; qh[k] = qh[k-1];
    end
    qv[0] = 1'b1; ql[0] = lo; qh[0] = hi;
    mdl[lo][hi] = 1'b1;
  endtask

  task automatic step(input bit cv, input int a, input int b,
                      input bit mv, input int ma, input int mb,
                      input bit c, input string tag);
    bit ev, eh;
    chk_vld = cv; chk_a = IW'(a); chk_b = IW'(b);
    cm_vld = mv; cm_a = IW'(ma); cm_b = IW'(mb); clr = c;
    ev = cv;
    eh = cv && mdl_hit(a, b);
    @(posedge clk);
    #1;
    checks++;
    if (hit_vld !== ev || hit !== eh) begin
      errs++;
      $display("FAIL %s: pair (%0d,%0d) hit_vld/hit actual %b/%b expected %b/%b",
               tag, a, b, hit_vld, hit, ev, eh);
    end
    if (c) mdl_reset();
    else if (mv) mdl_commit(ma, mb);
    chk_vld = 1'b0; cm_vld = 1'b0; clr = 1'b0;
  endtask

  task automatic ask(int a, int b, string tag);
    step(1'b1, a, b, 1'b0, 0, 0, 1'b0, tag);
    step(1'b0, 0, 0, 1'b0, 0, 0, 1'b0, tag);
  endtask

  task automatic put(int a, int b, string tag);
    step(1'b0, 0, 0, 1'b1, a, b, 1'b0, tag);
  endtask

  initial begin
    #1600000;
    errs++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    mdl_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8: empty after reset, R1 idle output quiet
    step(1'b0, 0, 0, 1'b0, 0, 0, 1'b0, "R8");
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) step(1'b1, i, j, 1'b0, 0, 0, 1'b0, "R8");

    // R3: same-cycle commit sees old state, later check sees new
    step(1'b1, 1, 4, 1'b1, 1, 4, 1'b0, "R3");
    ask(4, 1, "R2");
    ask(1, 4, "R3");
    // R4: fill to tenure, nothing lost
    put(1, 0, "R4"); put(3, 2, "R4"); put(0, 5, "R4");
    ask(1, 4, "R4"); ask(0, 1, "R4"); ask(2, 3, "R4");
    // R5: fifth commit evicts oldest (1,4)
    put(2, 5, "R5");
    ask(1, 4, "R5"); ask(5, 2, "R5");
    // R6: oldest now (0,1); re-commit it as (1,0)
    put(1, 0, "R6");
    ask(0, 1, "R6"); ask(0, 5, "R6");
    // R7: clear beats commit in same cycle
    step(1'b0, 0, 0, 1'b1, 3, 4, 1'b1, "R7");
    ask(3, 4, "R7"); ask(2, 5, "R7"); ask(0, 1, "R7");
    put(2, 4, "R7"); ask(4, 2, "R7");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit cv, mv, c;
      cv = ($urandom % 4) != 0;
      mv = ($urandom % 2) != 0;
      c  = ($urandom % 64) == 0;
      step(cv, int'($urandom % N), int'($urandom % N),
           mv, int'($urandom % N), int'($urandom % N), c, "R5");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule